// File: doc/BRIEF.md
# DDR ADC Sample Deinterleaver

This block rebuilds 12-bit parallel converter samples from a source-synchronous double-data-rate bus. The bus has six data lines. In every clock period each line delivers two bits, one on each clock edge. Line i carries one bit of the odd set and its even neighbour. The block captures both halves and pairs the two halves that belong to the same conversion. It places every bit in its proper position and presents the result as one registered sample with a valid strobe.

Two run-time controls correct board-level faults. The first selects which clock edge opens a sample, which covers a clock that is inverted somewhere on its way to the receiver. The second exchanges the odd and even positions, which covers a bus that delivers 10-11-8-9-...-0-1 instead of 11-10-...-0. Both controls are sampled on the rising edge. They take effect at the next sample boundary, and the valid strobe drops while the pipeline refills with data built under the new setting.

Top module: `ddr_sample_deinterleaver`

## Requirements
- R1: With rising-edge-first order (cfgFallFirst=0) and no swap (cfgSwapPairs=0), the bit on line i during the rising-edge half goes to sampleOut bit 2i+1 and the bit during the following falling-edge half goes to bit 2i.
- R2: With rising-edge-first order, the rising-edge half and the falling-edge half that follows it form one sample. It appears on sampleOut one rising edge after the edge that captured its rising half, and no bit comes from a neighbouring sample.
- R3: With falling-edge-first order (cfgFallFirst=1), a falling-edge half and the rising-edge half that follows it form one sample, with the same one-edge latency counted from the rising half.
- R4: With cfgSwapPairs=1, the first half of line i goes to bit 2i and the second half to bit 2i+1, in either edge order.
- R5: While rstN is low, sampleOut is 0 and sampleValid is 0. After release, sampleValid stays low for the first two rising edges and rises on the third.
- R6: When either control input differs from its last sampled value at a rising edge, sampleValid is low after the next two rising edges. The first valid sample after that is built entirely under the new setting.
- R7: A ramp that crosses midscale (2047 to 2048) is reproduced exactly, with no single-sample MSB glitch, in both edge orders.
- R8: While the controls are unchanged, sampleValid stays high on every rising edge and one sample is delivered per clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges carry data |
| rstN | input | 1 | Asynchronous active-low reset |
| ddrLines | input | 6 | Double-data-rate data lines |
| cfgFallFirst | input | 1 | 1: the falling-edge half opens a sample |
| cfgSwapPairs | input | 1 | 1: exchange odd and even bit positions |
| sampleOut | output | 12 | Rebuilt sample, bit 11 is the MSB |
| sampleValid | output | 1 | sampleOut holds a sample built under a settled configuration |

## Verification
The bench builds the block with its default parameters: six lines, which give a full 12-bit sample, and a refill depth of two. These values make the midscale step from 2047 to 2048 reachable, so the MSB and every lower bit toggle at once, and an edge-pairing error would show as a single wrong sample. The short refill depth lets the bench observe exactly the two missing valid strobes after a swap-control change. It also lets it follow every combination of edge order and swap within a short run.

// File: rtl/ddr_deint_pkg.sv
package ddr_deint_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic fallFirst;  // falling-edge half opens a sample
    logic swapPairs;  // exchange odd/even bit positions
    logic pipeFull;   // pipeline holds data of the current setting
  } ctrl_strobe_t;

endpackage

// File: rtl/ddr_deint_ctrl.sv
module ddr_deint_ctrl
  import ddr_deint_pkg::*;
#(
  parameter int FILL_CYCLES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgFallFirst,
  input  logic         cfgSwapPairs,
  output ctrl_strobe_t strobe
);

  localparam int CW = $clog2(FILL_CYCLES + 1);
  localparam logic [CW-1:0] FILL_LOAD = CW'(FILL_CYCLES);

  logic          fallFirstQ;
  logic          swapPairsQ;
  logic [CW-1:0] fillCount;
  logic          cfgChanged;

  assign cfgChanged = (cfgFallFirst != fallFirstQ) || (cfgSwapPairs != swapPairsQ);

  // Controls are sampled on the rising edge, i.e. at a sample boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallFirstQ <= 1'b0;
      swapPairsQ <= 1'b0;
    end else begin
      fallFirstQ <= cfgFallFirst;
      swapPairsQ <= cfgSwapPairs;
    end
  end

  // Refill counter: reloaded on reset and on any control change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= FILL_LOAD;
    end else if (cfgChanged) begin
      fillCount <= FILL_LOAD;
    end else if (fillCount != '0) begin
      fillCount <= fillCount - 1'b1;
    end
  end

  always_comb begin
    strobe.fallFirst = fallFirstQ;
    strobe.swapPairs = swapPairsQ;
    strobe.pipeFull  = (fillCount == '0);
  end

  // R6
  cfg_change_flush_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    cfgChanged |=> !strobe.pipeFull
  ) else $error("pipeline not flushed after control change");

  // R6
  full_drop_cause_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    (!strobe.pipeFull && $past(strobe.pipeFull)) |-> $past(cfgChanged)
  ) else $error("pipeline emptied without a control change");

endmodule

// File: rtl/ddr_deint_datapath.sv
module ddr_deint_datapath
  import ddr_deint_pkg::*;
#(
  parameter int LANES = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   ddrLines,
  input  ctrl_strobe_t       strobe,
  output logic [2*LANES-1:0] sampleOut,
  output logic               sampleValid
);

  localparam int WIDTH = 2 * LANES;

  logic [LANES-1:0] capRise;    // rising-edge half
  logic [LANES-1:0] capFall;    // falling-edge half
  logic [LANES-1:0] fallDly;    // falling half realigned to the rising domain
  logic [LANES-1:0] firstHalf;
  logic [LANES-1:0] secondHalf;
  logic [WIDTH-1:0] assembled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capRise <= '0;
    else       capRise <= ddrLines;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) capFall <= '0;
    else       capFall <= ddrLines;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fallDly <= '0;
    else       fallDly <= capFall;
  end

  // Pair halves of one sample period:
  //   rise first: rising half at edge k, falling half just after it
  //   fall first: falling half before edge k, rising half at edge k
  always_comb begin
    if (strobe.fallFirst) begin
      firstHalf  = fallDly;
      secondHalf = capRise;
    end else begin
      firstHalf  = capRise;
      secondHalf = capFall;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign assembled[2*g+1] = strobe.swapPairs ? secondHalf[g] : firstHalf[g];
    assign assembled[2*g]   = strobe.swapPairs ? firstHalf[g]  : secondHalf[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleOut   <= assembled;
      sampleValid <= strobe.pipeFull;
    end
  end

  // R6
  mode_switch_quiet_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    ((strobe.swapPairs != $past(strobe.swapPairs)) ||
     (strobe.fallFirst != $past(strobe.fallFirst))) |=> !sampleValid
  ) else $error("valid sample right after a mode switch");

endmodule

// File: rtl/ddr_sample_deinterleaver.sv
module ddr_sample_deinterleaver
  import ddr_deint_pkg::*;
#(
  parameter int LANES       = 6,
  parameter int FILL_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   ddrLines,
  input  logic               cfgFallFirst,
  input  logic               cfgSwapPairs,
  output logic [2*LANES-1:0] sampleOut,
  output logic               sampleValid
);

  ctrl_strobe_t strobe;

  ddr_deint_ctrl #(
    .FILL_CYCLES(FILL_CYCLES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgFallFirst(cfgFallFirst),
    .cfgSwapPairs(cfgSwapPairs),
    .strobe      (strobe)
  );

  ddr_deint_datapath #(
    .LANES(LANES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .ddrLines   (ddrLines),
    .strobe     (strobe),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

  // R6
  valid_needs_steady_cfg_chk: assert property (
    @(posedge clk) disable iff (!rstN)
    sampleValid |-> $past((cfgFallFirst == strobe.fallFirst) &&
                          (cfgSwapPairs == strobe.swapPairs), 2)
  ) else $error("valid sample too soon after a control change");

endmodule

// File: tb/tb_ddr_sample_deinterleaver.sv
module tb_ddr_sample_deinterleaver;

  localparam int L = 6;
  localparam int W = 2 * L;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [L-1:0] ddrLines = '0;
  logic         cfgFallFirst = 1'b0;
  logic         cfgSwapPairs = 1'b0;
  logic [W-1:0] sampleOut;
  logic         sampleValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] seqVals [0:31];
  int           seqLen;
  logic [W-1:0] gotVal [0:255];
  int           gotCyc [0:255];
  int           nGot = 0;
  int           cyc = 0;

  ddr_sample_deinterleaver dut (
    .clk(clk), .rstN(rstN), .ddrLines(ddrLines),
    .cfgFallFirst(cfgFallFirst), .cfgSwapPairs(cfgSwapPairs),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Output monitor, samples 6 ns after each rising edge
  always @(posedge clk) begin
    #6;
    cyc++;
    if (rstN && sampleValid && nGot < 256) begin
      gotVal[nGot] = sampleOut;
      gotCyc[nGot] = cyc;
      nGot++;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] oddHalf(input logic [W-1:0] v);
    for (int i = 0; i < L; i++) oddHalf[i] = v[2*i+1];
  endfunction

  function automatic logic [L-1:0] evenHalf(input logic [W-1:0] v);
    for (int i = 0; i < L; i++) evenHalf[i] = v[2*i];
  endfunction

  task automatic putBeforeRise(input logic [L-1:0] h);
    @(negedge clk); #4; ddrLines = h;
  endtask

  task automatic putBeforeFall(input logic [L-1:0] h);
    @(posedge clk); #4; ddrLines = h;
  endtask

  // Sends one sample the way a bus with the given faults would deliver it
  task automatic sendSample(input logic [W-1:0] v, input bit ff, input bit sw);
    logic [L-1:0] first, second;
    first  = sw ? evenHalf(v) : oddHalf(v);
    second = sw ? oddHalf(v)  : evenHalf(v);
    if (!ff) begin
      putBeforeRise(first);
      putBeforeFall(second);
    end else begin
      putBeforeFall(first);
      putBeforeRise(second);
    end
  endtask

  // Streams seqVals between zero fillers and compares the valid outputs
  task automatic runStream(input bit ff, input bit sw, input string req);
    int k;
    cfgFallFirst = ff;
    cfgSwapPairs = sw;
    nGot = 0;
    repeat (4) sendSample('0, ff, sw);
    for (int j = 0; j < seqLen; j++) sendSample(seqVals[j], ff, sw);
    repeat (4) sendSample('0, ff, sw);
    k = -1;
    for (int i = 0; i < nGot; i++) if (k < 0 && gotVal[i] != '0) k = i;
    if (k < 0) begin
      check(1'b0, req, '0, seqVals[0]);
    end else begin
      for (int j = 0; j < seqLen; j++) begin
        if (k + j >= nGot) check(1'b0, req, '0, seqVals[j]);
        else check(gotVal[k+j] == seqVals[j], req, gotVal[k+j], seqVals[j]);
        // R8: one valid sample on every clock while controls are steady
        if (j > 0 && k + j < nGot)
          check(gotCyc[k+j] == gotCyc[k+j-1] + 1, "R8 continuous valid",
                W'(gotCyc[k+j] - gotCyc[k+j-1]), W'(1));
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(sampleOut == '0, "R5 reset data", sampleOut, '0);
    check(sampleValid == 1'b0, "R5 reset valid", W'(sampleValid), '0);
    rstN = 1'b1;
    @(posedge clk); #6;
    check(sampleValid == 1'b0, "R5 edge1 valid", W'(sampleValid), '0);
    @(posedge clk); #6;
    check(sampleValid == 1'b0, "R5 edge2 valid", W'(sampleValid), '0);
    @(posedge clk); #6;
    check(sampleValid == 1'b1, "R5 edge3 valid", W'(sampleValid), W'(1));
    check(sampleOut == '0, "R5 edge3 data", sampleOut, '0);
  endtask

  task automatic setPatterns();
    seqVals[0] = 12'h801; seqVals[1] = 12'h001; seqVals[2] = 12'h800;
    seqVals[3] = 12'h5A3; seqVals[4] = 12'hC3C; seqVals[5] = 12'hAAA;
    seqVals[6] = 12'h555; seqVals[7] = 12'hFFF; seqVals[8] = 12'h123;
    seqLen = 9;
  endtask

  task automatic setRamp(input int up);
    for (int j = 0; j < 16; j++) seqVals[j] = up ? W'(2040 + j) : W'(2055 - j);
    seqLen = 16;
  endtask

  // R6: swap toggled mid-stream; lines carry all ones on the rising half
  task automatic testCfgFlush();
    for (int j = 0; j < 6; j++) begin
      if (j == 2) cfgSwapPairs = 1'b1;
      putBeforeRise('1);
      putBeforeFall('0);
      #2;
      case (j)
        1: begin
          check(sampleValid == 1'b1, "R6 steady valid", W'(sampleValid), W'(1));
          check(sampleOut == 12'hAAA, "R6 steady data", sampleOut, 12'hAAA);
        end
        2: begin
          check(sampleValid == 1'b1, "R6 old setting valid", W'(sampleValid), W'(1));
          check(sampleOut == 12'hAAA, "R6 old setting data", sampleOut, 12'hAAA);
        end
        3: check(sampleValid == 1'b0, "R6 flush1", W'(sampleValid), '0);
        4: check(sampleValid == 1'b0, "R6 flush2", W'(sampleValid), '0);
        5: begin
          check(sampleValid == 1'b1, "R6 refilled valid", W'(sampleValid), W'(1));
          check(sampleOut == 12'h555, "R6 new setting data", sampleOut, 12'h555);
        end
        default: ;
      endcase
    end
    cfgSwapPairs = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    setPatterns(); runStream(1'b0, 1'b0, "R1 rise-first bit map");
    setRamp(1);    runStream(1'b0, 1'b0, "R2 R7 rise-first midscale up");
    setRamp(0);    runStream(1'b0, 1'b0, "R2 R7 rise-first midscale down");
    setRamp(1);    runStream(1'b1, 1'b0, "R3 R7 fall-first midscale up");
    setPatterns(); runStream(1'b1, 1'b0, "R3 fall-first bit map");
    setPatterns(); runStream(1'b0, 1'b1, "R4 swap rise-first");
    setPatterns(); runStream(1'b1, 1'b1, "R4 swap fall-first");
    setRamp(0);    runStream(1'b1, 1'b1, "R4 R7 swap fall-first midscale");
    setPatterns(); runStream(1'b0, 1'b0, "R1 restore");
    testCfgFlush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule